// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns two reserved words at the top of the address space into a doorbell between the ports. It does not store the message word. It watches each port's access controls and keeps one interrupt bit per port. A port leaves a message by writing into the other port's mailbox word. That write raises the owner's interrupt. The owner acknowledges the message by reading its own mailbox word, which drops the interrupt.

The right port owns the word at the highest address, `2^AW-1`. The left port owns the word one below it, `2^AW-2`. A port may read the other port's mailbox without disturbing anything. When a port's contention flag is active, that port can neither raise the peer's interrupt nor acknowledge its own. The block has no data stream. Every pin is a plain level control, so there is no valid/ready handshake and no back-pressure.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `l_irq_n` and `r_irq_n` are high (inactive) until a setting event occurs.
- R2: A left-port write cycle (`l_en`=1, `l_we`=1) to address `2^AW-1` with `l_busy`=0 drives `r_irq_n` low from the next rising clock edge.
- R3: A right-port write cycle (`r_en`=1, `r_we`=1) to address `2^AW-2` with `r_busy`=0 drives `l_irq_n` low from the next rising clock edge.
- R4: An owner read cycle (enable=1, write=0, output enable=1) with busy=0 returns that port's interrupt output high at the next rising edge. For the right port this is a read of `2^AW-1`; for the left port it is a read of `2^AW-2`.
- R5: A port reading the other port's mailbox address changes neither interrupt output.
- R6: While a port's busy input is 1, its write to the peer's mailbox does not assert the peer's interrupt.
- R7: While a port's busy input is 1, its read of its own mailbox does not clear its interrupt.
- R8: If the same interrupt receives a valid set and a valid clear in the same cycle, it ends up asserted (low).
- R9: The following leave both interrupt outputs unchanged: any access with enable at 0, a read with output enable at 0, any access to an address below `2^AW-2`, and a port's write to its own mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port access enable, active high |
| l_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable, active high |
| l_busy | input | 1 | Left port contention flag, active high |
| l_addr | input | AW | Left port word address |
| r_en | input | 1 | Right port access enable, active high |
| r_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable, active high |
| r_busy | input | 1 | Right port contention flag, active high |
| r_addr | input | AW | Right port word address |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every set or clear takes effect at the first rising edge that samples the qualifying access. The new interrupt level therefore appears one cycle after the stimulus. Reset acts at once, without waiting for a clock. The bench drives inputs on falling edges and compares both outputs on the next falling edge, half a period after the capturing edge. Before each case it rebuilds the starting interrupt state through its own reset and doorbell cycle, and it confirms that state one cycle later, so each result is checked against a known prior state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int N_SIDES = 2;

  // Mailbox word owned by a side: right owns the top word, left the one below.
  function automatic logic [31:0] box_addr(input int aw, input int side);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (side == SIDE_L) ? (top - 32'd1) : top;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] OWN_ADDR = '1,
  parameter logic [AW-1:0] PEER_ADDR = '0
) (
  input  logic          en,
  input  logic          we,
  input  logic          oe,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  output logic          peer_wr,
  output logic          own_rd
);

  logic hit_own;
  logic hit_peer;
  logic wr_cyc;
  logic rd_cyc;

  always_comb begin
    hit_own  = (addr == OWN_ADDR);
    hit_peer = (addr == PEER_ADDR);
    wr_cyc   = en & we;
    rd_cyc   = en & ~we & oe;
    // contention on this port blocks both doorbell and acknowledge
    peer_wr  = wr_cyc & hit_peer & ~busy;
    own_rd   = rd_cyc & hit_own & ~busy;
  end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;   // set outranks clear
    else if (clr_req) flag_q <= 1'b0;
  end

  assign irq_n = ~flag_q;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> !irq_n);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> irq_n);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic          l_busy,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic          r_busy,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  import mbx_pkg::*;

  localparam int NS = N_SIDES;

  logic [NS-1:0]         p_en, p_we, p_oe, p_busy;
  logic [NS-1:0][AW-1:0] p_addr;
  logic [NS-1:0]         peer_wr, own_rd, irq_n_v;

  assign p_en[SIDE_L]   = l_en;
  assign p_we[SIDE_L]   = l_we;
  assign p_oe[SIDE_L]   = l_oe;
  assign p_busy[SIDE_L] = l_busy;
  assign p_addr[SIDE_L] = l_addr;
  assign p_en[SIDE_R]   = r_en;
  assign p_we[SIDE_R]   = r_we;
  assign p_oe[SIDE_R]   = r_oe;
  assign p_busy[SIDE_R] = r_busy;
  assign p_addr[SIDE_R] = r_addr;

  for (genvar s = 0; s < NS; s++) begin : g_side
    localparam logic [AW-1:0] OWN_A  = AW'(box_addr(AW, s));
    localparam logic [AW-1:0] PEER_A = AW'(box_addr(AW, NS - 1 - s));

    mbx_port_decode #(.AW(AW), .OWN_ADDR(OWN_A), .PEER_ADDR(PEER_A)) u_dec (
      .en(p_en[s]), .we(p_we[s]), .oe(p_oe[s]), .busy(p_busy[s]),
      .addr(p_addr[s]), .peer_wr(peer_wr[s]), .own_rd(own_rd[s])
    );

    // this side's flag is set by the other side and cleared by itself
    mbx_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_req(peer_wr[NS - 1 - s]), .clr_req(own_rd[s]),
      .irq_n(irq_n_v[s])
    );
  end

  assign l_irq_n = irq_n_v[SIDE_L];
  assign r_irq_n = irq_n_v[SIDE_R];

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (l_irq_n && r_irq_n));
  a_r6_busy_no_ring_r: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy && r_irq_n) |=> r_irq_n);
  a_r6_busy_no_ring_l: assert property (@(posedge clk) disable iff (!rst_n)
    (r_busy && l_irq_n) |=> l_irq_n);
  a_r7_busy_no_ack_l: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy && !l_irq_n) |=> !l_irq_n);
  a_r7_busy_no_ack_r: assert property (@(posedge clk) disable iff (!rst_n)
    (r_busy && !r_irq_n) |=> !r_irq_n);

endmodule

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;
  localparam int AW = 4;
  localparam logic [AW-1:0] RBOX = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] LBOX = AW'((1 << AW) - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en, l_we, l_oe, l_busy, r_en, r_we, r_oe, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_irq_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // port field word: [0]=en [1]=we [2]=oe [3]=busy [5:4]=address select
  function automatic logic [AW-1:0] addr_of(input logic [1:0] sel);
    case (sel)
      2'd0: return RBOX;
      2'd1: return LBOX;
      2'd2: return '0;
      default: return AW'(5);
    endcase
  endfunction

  function automatic bit is_set(input logic [5:0] f, input logic [AW-1:0] box);
    return f[0] && f[1] && !f[3] && addr_of(f[5:4]) == box;
  endfunction

  function automatic bit is_clr(input logic [5:0] f, input logic [AW-1:0] box);
    return f[0] && !f[1] && f[2] && !f[3] && addr_of(f[5:4]) == box;
  endfunction

  // which requirement governs one side's result for given owner/peer fields
  function automatic string tag_of(input logic [5:0] own, input logic [5:0] peer,
                                   input logic [AW-1:0] box);
    bit s, c;
    s = is_set(peer, box);
    c = is_clr(own, box);
    if (s && c) return "R8";
    if (s) return (box == RBOX) ? "R2" : "R3";
    if (c) return "R4";
    if (peer[0] && peer[1] && peer[3] && addr_of(peer[5:4]) == box) return "R6";
    if (own[0] && !own[1] && own[2] && own[3] && addr_of(own[5:4]) == box) return "R7";
    if (peer[0] && !peer[1] && addr_of(peer[5:4]) == box) return "R5";
    return "R9";
  endfunction

  task automatic drive(input logic [5:0] lf, input logic [5:0] rf);
    l_en = lf[0]; l_we = lf[1]; l_oe = lf[2]; l_busy = lf[3]; l_addr = addr_of(lf[5:4]);
    r_en = rf[0]; r_we = rf[1]; r_oe = rf[2]; r_busy = rf[3]; r_addr = addr_of(rf[5:4]);
  endtask

  task automatic check(input string tag, input logic [1:0] exp_act);
    // exp_act[0]=left asserted, [1]=right asserted
    logic exp_l, exp_r;
    exp_l = ~exp_act[0];
    exp_r = ~exp_act[1];
    checks++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      errors++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l_irq_n=%b r_irq_n=%b",
               tag, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  // st[0]=left interrupt active at start, st[1]=right active at start
  task automatic run_case(input logic [1:0] st, input logic [5:0] lf,
                          input logic [5:0] rf, input string force_tag);
    logic sl, cl, sr, cr;
    logic [1:0] nx;
    string tg;
    @(negedge clk); rst_n = 1'b0; drive(6'd0, 6'd0);
    @(negedge clk); rst_n = 1'b1;
    drive(st[1] ? 6'b00_0011 : 6'd0, st[0] ? 6'b01_0011 : 6'd0);
    @(negedge clk);
    check(st[1] ? "R2" : (st[0] ? "R3" : "R9"), st);
    drive(lf, rf);
    @(negedge clk);
    sl = is_set(rf, LBOX); cl = is_clr(lf, LBOX);
    sr = is_set(lf, RBOX); cr = is_clr(rf, RBOX);
    nx[0] = sl ? 1'b1 : (cl ? 1'b0 : st[0]);
    nx[1] = sr ? 1'b1 : (cr ? 1'b0 : st[1]);
    if (force_tag != "") tg = force_tag;
    else if (nx[0] != st[0] || tag_of(lf, rf, LBOX) != "R9") tg = tag_of(lf, rf, LBOX);
    else tg = tag_of(rf, lf, RBOX);
    check(tg, nx);
    drive(6'd0, 6'd0);
  endtask

  initial begin
    drive(6'd0, 6'd0);
    @(negedge clk);
    check("R1", 2'b00);                                  // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);                                  // R1 after release
    run_case(2'b00, 6'b00_0011, 6'd0, "R2");             // left rings right
    run_case(2'b00, 6'd0, 6'b01_0011, "R3");             // right rings left
    run_case(2'b10, 6'd0, 6'b00_0101, "R4");             // right acks own
    run_case(2'b01, 6'b01_0101, 6'd0, "R4");             // left acks own
    run_case(2'b11, 6'b00_0101, 6'b01_0101, "R5");       // cross reads
    run_case(2'b00, 6'b00_1011, 6'b01_1011, "R6");       // busy writes
    run_case(2'b11, 6'b01_1101, 6'b00_1101, "R7");       // busy acks
    run_case(2'b10, 6'b00_0011, 6'b00_0101, "R8");       // set vs clear right
    run_case(2'b01, 6'b01_0101, 6'b01_0011, "R8");       // set vs clear left
    run_case(2'b11, 6'b01_0001, 6'b00_0001, "R9");       // own read, oe low
    run_case(2'b00, 6'b01_0011, 6'b00_0011, "R9");       // writes to own box
    run_case(2'b00, 6'b00_0010, 6'b01_0010, "R9");       // enable low
    // near-exhaustive sweep: start state x both ports' field words
    for (int c = 0; c < 16384; c++) begin
      run_case(c[1:0], c[7:2], c[13:8], "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule